// File: doc/BRIEF.md
# Multi-port GPIO pad mode controller

This block is a memory-mapped general-purpose I/O controller for up to seven ports of eight pins each. Each port owns a register window at a fixed byte stride. Inside the window there are four registers: a read-only view of the synchronised pad levels, an output value latch, a pin mode register with a 2-bit field per pin, and a pull-up control register. The block turns these registers into three signals for every pad: the value to drive, an output enable and a pull-up enable.

Each pin picks one of four drive behaviours: input only, push-pull, open-drain or open-source. Pull-ups are programmed active-low, so a 0 in a pin's pull bit asks for the pull-up. A single global register reports how many 8-pin cores are present and a version code. It also holds two control bits. One of them is the block enable: while it is clear, nothing reaches the pads, but software can still program every register. This lets the pads be configured before they are released.

Accesses use a simple single-cycle bus with select, write enable, byte address and write data. Read data is registered and appears the cycle after the read request. The bus returns zero whenever no read was requested in the previous cycle.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: Port p's registers sit at byte address p*0x30 plus a window offset: 0x04 pad input, 0x08 output latch, 0x0C pin mode, 0x10 pull control. The global register sits at address 0x00. Read data appears on busRdata in the cycle after the read request and is zero in any cycle that follows no read.
- R2: The global register reads back NUM_PORTS in bits 15:9, CORE_VERSION in bits 8:2 and the two writable control bits in bits 1:0 (bit 0 is the block enable, bit 1 is the sync-select flag). All other bits read zero, and writes to them are dropped.
- R3: After reset, every mode field is 00, every output latch and pull bit is 0, the global control bits are 0, and all padOut, padOe and padPullEn bits are low.
- R4: While global bit 0 is 0, every padOut, padOe and padPullEn bit is low, whatever the port registers hold. Register writes made during that time still take effect once the block is enabled again.
- R5: Mode 00 (input): the pin's padOe and padOut are low.
- R6: Mode 01 (push-pull): padOe is high and padOut equals the pin's latch bit.
- R7: Mode 10 (open-drain): padOe is high only when the latch bit is 0, and padOut is low.
- R8: Mode 11 (open-source): padOe is high only when the latch bit is 1, and padOut is high.
- R9: For an enabled block, padPullEn of a pin is high when its pull bit is 0 and low when it is 1. Only bits 7:0 of the pull and output registers and bits 15:0 of the mode register are stored; higher bits read as zero. Pin n's mode field is at bits 2n+1:2n.
- R10: The pad input register shows padIn through a two-flop synchroniser. A level applied just before a read request is seen by the third consecutive read and not by the first two. Writes to the input offset change no register.
- R11: Unimplemented addresses read as zero and ignore writes. These include offset 0x00 of ports other than 0, offsets 0x14 and above in a window, non-word-aligned addresses and addresses past the last port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request this cycle |
| busWe | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| padIn | input | NUM_PORTS*8 | Pad input levels (asynchronous) |
| padOut | output | NUM_PORTS*8 | Value driven to each pad |
| padOe | output | NUM_PORTS*8 | Output enable for each pad |
| padPullEn | output | NUM_PORTS*8 | Pull-up enable for each pad |

## Verification
Several properties are checked on every clock edge:
- the read bus idles at zero and returns zero for unmapped reads;
- a write that clears the enable silences all pads on the next cycle;
- the synchroniser output equals the pad level of two edges earlier;
- a write to the input offset leaves all stored state unchanged.

Other behaviours can only be shown by the bench's scenarios, because they depend on software-chosen register contents. These are the per-mode pad encodings across mixed pin patterns, the exact three-read latency of a new pad level, the truncation of wide writes, and the retention of writes made while the block is off.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

  localparam int PINS_PER_PORT = 8;
  localparam int PORT_W        = 3;
  localparam int DATA_W        = 32;

  // byte offsets inside one port window
  localparam logic [31:0] OFF_GLOBAL = 32'h00;
  localparam logic [31:0] OFF_INPUT  = 32'h04;
  localparam logic [31:0] OFF_OUTPUT = 32'h08;
  localparam logic [31:0] OFF_MODE   = 32'h0C;
  localparam logic [31:0] OFF_PULL   = 32'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GLOBAL,
    SEL_INPUT,
    SEL_OUTPUT,
    SEL_MODE,
    SEL_PULL
  } regSel_e;

  typedef enum logic [1:0] {
    MODE_INPUT  = 2'b00,
    MODE_PUSH   = 2'b01,
    MODE_DRAIN  = 2'b10,
    MODE_SOURCE = 2'b11
  } pinMode_e;

  // strobes from the address decoder to the register datapath
  typedef struct packed {
    logic              wrStb;
    logic              rdStb;
    regSel_e           sel;
    logic [PORT_W-1:0] port;
  } regStrobe_t;

endpackage

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PORTS   = 7,
  parameter int PORT_STRIDE = 48,
  parameter int ADDR_W      = 10
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);

  logic [31:0]       addrWide;
  logic [31:0]       winOff;
  logic [PORT_W-1:0] hitPort;
  logic              found;

  // find which port window the address falls in
  always_comb begin
    addrWide = 32'(busAddr);
    found    = 1'b0;
    hitPort  = '0;
    winOff   = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addrWide >= 32'(p * PORT_STRIDE) &&
          addrWide <  32'((p + 1) * PORT_STRIDE)) begin
        found   = 1'b1;
        hitPort = PORT_W'(p);
        winOff  = addrWide - 32'(p * PORT_STRIDE);
      end
    end
  end

  // turn the window offset into a register select
  always_comb begin
    strobe       = '0;
    strobe.sel   = SEL_NONE;
    strobe.port  = hitPort;
    strobe.rdStb = busSel & ~busWe;
    strobe.wrStb = busSel & busWe;
    if (found) begin
      case (winOff)
        OFF_GLOBAL: strobe.sel = (hitPort == '0) ? SEL_GLOBAL : SEL_NONE;
        OFF_INPUT:  strobe.sel = SEL_INPUT;
        OFF_OUTPUT: strobe.sel = SEL_OUTPUT;
        OFF_MODE:   strobe.sel = SEL_MODE;
        OFF_PULL:   strobe.sel = SEL_PULL;
        default:    strobe.sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_pad_pkg::*;
(
  input  logic       blockOn,
  input  logic [1:0] modeBits,
  input  logic       latchVal,
  input  logic       pullOff,
  output logic       padOut,
  output logic       padOe,
  output logic       padPullEn
);

  logic rawOut;
  logic rawOe;

  always_comb begin
    case (pinMode_e'(modeBits))
      MODE_PUSH: begin
        rawOe  = 1'b1;
        rawOut = latchVal;
      end
      MODE_DRAIN: begin
        rawOe  = ~latchVal;   // only ever pulls low
        rawOut = 1'b0;
      end
      MODE_SOURCE: begin
        rawOe  = latchVal;    // only ever pushes high
        rawOut = 1'b1;
      end
      default: begin
        rawOe  = 1'b0;
        rawOut = 1'b0;
      end
    endcase
  end

  assign padOe     = blockOn & rawOe;
  assign padOut    = blockOn & rawOut;
  assign padPullEn = blockOn & ~pullOff;

endmodule

// File: rtl/gpio_pad_regs.sv
module gpio_pad_regs
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PORTS    = 7,
  parameter int CORE_VERSION = 5,
  localparam int NPINS       = NUM_PORTS * PINS_PER_PORT
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NPINS-1:0]  padIn,
  output logic [NPINS-1:0]  padOut,
  output logic [NPINS-1:0]  padOe,
  output logic [NPINS-1:0]  padPullEn
);

  logic [NPINS-1:0]   outFlat;
  logic [2*NPINS-1:0] modeFlat;
  logic [NPINS-1:0]   pullFlat;
  logic [1:0]         glbCtl;
  logic [NPINS-1:0]   syncA;
  logic [NPINS-1:0]   syncB;
  logic [DATA_W-1:0]  rdNext;
  logic               unusedWdataHi;

  assign unusedWdataHi = ^busWdata[DATA_W-1:16];

  // register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outFlat  <= '0;
      modeFlat <= '0;
      pullFlat <= '0;
      glbCtl   <= '0;
    end else if (strobe.wrStb) begin
      if (strobe.sel == SEL_GLOBAL) glbCtl <= busWdata[1:0];
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strobe.port == PORT_W'(p)) begin
          case (strobe.sel)
            SEL_OUTPUT: outFlat[p*8 +: 8]   <= busWdata[7:0];
            SEL_MODE:   modeFlat[p*16 +: 16] <= busWdata[15:0];
            SEL_PULL:   pullFlat[p*8 +: 8]  <= busWdata[7:0];
            default: ;
          endcase
        end
      end
    end
  end

  // two-flop pad input synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  // read mux
  always_comb begin
    rdNext = '0;
    if (strobe.sel == SEL_GLOBAL)
      rdNext = {16'b0, 7'(NUM_PORTS), 7'(CORE_VERSION), glbCtl};
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (strobe.port == PORT_W'(p)) begin
        case (strobe.sel)
          SEL_INPUT:  rdNext = {24'b0, syncB[p*8 +: 8]};
          SEL_OUTPUT: rdNext = {24'b0, outFlat[p*8 +: 8]};
          SEL_MODE:   rdNext = {16'b0, modeFlat[p*16 +: 16]};
          SEL_PULL:   rdNext = {24'b0, pullFlat[p*8 +: 8]};
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= strobe.rdStb ? rdNext : '0;
  end

  // per-pin pad behaviour
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin_drive u_drive (
      .blockOn  (glbCtl[0]),
      .modeBits (modeFlat[2*i +: 2]),
      .latchVal (outFlat[i]),
      .pullOff  (pullFlat[i]),
      .padOut   (padOut[i]),
      .padOe    (padOe[i]),
      .padPullEn(padPullEn[i])
    );
  end

  // cycles since reset, saturating, for the synchroniser property
  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warmCnt <= '0;
    else if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
  end

  p_idle_read_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdStb |=> busRdata == '0);

  p_unmapped_read_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdStb && strobe.sel == SEL_NONE) |=> busRdata == '0);

  p_disable_silences_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStb && strobe.sel == SEL_GLOBAL && !busWdata[0])
      |=> (padOe == '0 && padOut == '0 && padPullEn == '0));

  p_sync_depth_r10: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd2) |-> syncB == $past(padIn, 2));

  p_input_write_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStb && strobe.sel == SEL_INPUT)
      |=> ($stable(outFlat) && $stable(modeFlat) && $stable(pullFlat) && $stable(glbCtl)));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PORTS    = 7,
  parameter int PORT_STRIDE  = 48,
  parameter int CORE_VERSION = 5,
  parameter int ADDR_W       = 10,
  localparam int NPINS       = NUM_PORTS * PINS_PER_PORT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [NPINS-1:0]  padIn,
  output logic [NPINS-1:0]  padOut,
  output logic [NPINS-1:0]  padOe,
  output logic [NPINS-1:0]  padPullEn
);

  regStrobe_t strobe;

  gpio_pad_decode #(
    .NUM_PORTS  (NUM_PORTS),
    .PORT_STRIDE(PORT_STRIDE),
    .ADDR_W     (ADDR_W)
  ) u_decode (
    .busSel (busSel),
    .busWe  (busWe),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  gpio_pad_regs #(
    .NUM_PORTS   (NUM_PORTS),
    .CORE_VERSION(CORE_VERSION)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .padPullEn(padPullEn)
  );

endmodule

// File: tb/gpio_pad_ctrl_tb_top.sv
module gpio_pad_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NPORTS     = 7;
  localparam int NPINS      = NPORTS * 8;
  localparam int STRIDE     = 48;
  localparam int ADDR_W     = 10;
  localparam logic [31:0] GLB_ID = 32'h0000_0E14; // 7<<9 | 5<<2
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [2:0]  port;
    logic [15:0] mode;
    logic [7:0]  outv;
    logic [7:0]  pullv;
    logic [7:0]  expOe;
    logic [7:0]  expOut;
    logic [7:0]  expPull;
  } vecT;

  localparam int NVEC = 5;
  localparam vecT VECS [NVEC] = '{
    '{3'd0, 16'h0000, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF},  // R5 all input
    '{3'd1, 16'h5555, 8'hA5, 8'hFF, 8'hFF, 8'hA5, 8'h00},  // R6 push-pull
    '{3'd2, 16'hAAAA, 8'h0F, 8'h0F, 8'hF0, 8'h00, 8'hF0},  // R7 open-drain
    '{3'd3, 16'hFFFF, 8'h3C, 8'h55, 8'h3C, 8'hFF, 8'hAA},  // R8 open-source
    '{3'd6, 16'hE4E4, 8'h66, 8'h81, 8'h22, 8'hAA, 8'h7E}   // mixed modes
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [NPINS-1:0]  padIn = '0;
  logic [NPINS-1:0]  padOut;
  logic [NPINS-1:0]  padOe;
  logic [NPINS-1:0]  padPullEn;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pad_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPullEn(padPullEn)
  );

  function automatic logic [ADDR_W-1:0] regAddr(int port, int off);
    return ADDR_W'(port * STRIDE + off);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic busWrite(logic [ADDR_W-1:0] a, logic [31:0] d);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(logic [ADDR_W-1:0] a, output logic [31:0] d);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busSel = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [NPINS-1:0] padVal;
    repeat (3) @(negedge clk);
    // R3: reset state while held in reset
    check("R3 oe in reset", 64'(padOe), 64'h0);
    check("R3 pullEn in reset", 64'(padPullEn), 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    busRead(regAddr(0, 'h0C), rd); check("R3 mode reset", 64'(rd), 64'h0);
    busRead(regAddr(3, 'h08), rd); check("R3 output reset", 64'(rd), 64'h0);
    busRead(regAddr(2, 'h10), rd); check("R3 pull reset", 64'(rd), 64'h0);
    busRead(regAddr(0, 'h00), rd); check("R2 R3 global reset", 64'(rd), 64'(GLB_ID));
    check("R4 pads off after reset", 64'(padOut | padOe | padPullEn), 64'h0);

    // R2: only bits 1:0 writable
    busWrite(regAddr(0, 0), 32'hFFFF_FFFF);
    busRead(regAddr(0, 0), rd); check("R2 global all ones", 64'(rd), 64'(GLB_ID | 32'h3));
    busWrite(regAddr(0, 0), 32'h1);
    busRead(regAddr(0, 0), rd); check("R2 global enable", 64'(rd), 64'(GLB_ID | 32'h1));
    check("R9 pull-ups on with pull bits 0", 64'(padPullEn), 64'({NPINS{1'b1}}));

    // table of mode / latch / pull patterns
    for (int v = 0; v < NVEC; v++) begin
      int p;
      p = int'(VECS[v].port);
      busWrite(regAddr(p, 'h0C), 32'(VECS[v].mode));
      busWrite(regAddr(p, 'h08), 32'(VECS[v].outv));
      busWrite(regAddr(p, 'h10), 32'(VECS[v].pullv));
      check($sformatf("R5-R8 vec%0d oe", v), 64'(padOe[p*8 +: 8]), 64'(VECS[v].expOe));
      check($sformatf("R5-R8 vec%0d out", v), 64'(padOut[p*8 +: 8]), 64'(VECS[v].expOut));
      check($sformatf("R9 vec%0d pullEn", v), 64'(padPullEn[p*8 +: 8]), 64'(VECS[v].expPull));
      busRead(regAddr(p, 'h0C), rd); check($sformatf("R1 vec%0d mode rb", v), 64'(rd), 64'(VECS[v].mode));
      busRead(regAddr(p, 'h08), rd); check($sformatf("R1 vec%0d out rb", v), 64'(rd), 64'(VECS[v].outv));
      busRead(regAddr(p, 'h10), rd); check($sformatf("R1 vec%0d pull rb", v), 64'(rd), 64'(VECS[v].pullv));
    end

    // R1: bus idles at zero the cycle after a read
    @(negedge clk);
    check("R1 idle read data", 64'(busRdata), 64'h0);

    // R4: disable silences pads, writes still land
    busWrite(regAddr(0, 0), 32'h0);
    check("R4 off oe", 64'(padOe), 64'h0);
    check("R4 off out", 64'(padOut), 64'h0);
    check("R4 off pullEn", 64'(padPullEn), 64'h0);
    busWrite(regAddr(5, 'h08), 32'h11);
    busWrite(regAddr(0, 0), 32'h1);
    busRead(regAddr(5, 'h08), rd); check("R4 write while off kept", 64'(rd), 64'h11);
    check("R4 push-pull back after enable", 64'(padOe[8 +: 8]), 64'hFF);

    // R9: upper bits are dropped
    busWrite(regAddr(0, 'h0C), 32'hFFFF_0001);
    busRead(regAddr(0, 'h0C), rd); check("R9 mode width", 64'(rd), 64'h0001);
    busWrite(regAddr(0, 'h10), 32'h0000_01FF);
    busRead(regAddr(0, 'h10), rd); check("R9 pull width", 64'(rd), 64'hFF);
    busWrite(regAddr(0, 'h08), 32'h0000_0ABC);
    busRead(regAddr(0, 'h08), rd); check("R9 output width", 64'(rd), 64'hBC);

    // R10: input synchroniser latency
    padVal = 56'h0123456789ABCD;
    padIn = padVal;
    busRead(regAddr(2, 'h04), rd); check("R10 first read old level", 64'(rd), 64'h0);
    busRead(regAddr(2, 'h04), rd); check("R10 second read old level", 64'(rd), 64'h0);
    busRead(regAddr(2, 'h04), rd); check("R10 third read new level", 64'(rd), 64'h89);
    busRead(regAddr(0, 'h04), rd); check("R10 port0 input", 64'(rd), 64'hCD);
    busWrite(regAddr(2, 'h04), 32'hFF);
    busRead(regAddr(2, 'h04), rd); check("R10 input write ignored", 64'(rd), 64'h89);
    busRead(regAddr(2, 'h0C), rd); check("R10 mode untouched", 64'(rd), 64'hAAAA);

    // R11: unimplemented addresses
    busRead(regAddr(0, 'h14), rd); check("R11 offset 0x14", 64'(rd), 64'h0);
    busRead(regAddr(1, 'h00), rd); check("R11 port1 offset 0", 64'(rd), 64'h0);
    busWrite(regAddr(1, 'h00), 32'h0);
    busRead(regAddr(0, 'h00), rd); check("R11 port1 offset 0 write", 64'(rd), 64'(GLB_ID | 32'h1));
    busWrite(regAddr(0, 'h09), 32'h77);
    busRead(regAddr(0, 'h08), rd); check("R11 misaligned write", 64'(rd), 64'hBC);
    busRead(regAddr(3, 'h0D), rd); check("R11 misaligned read", 64'(rd), 64'h0);
    busRead(regAddr(7, 'h08), rd); check("R11 past last port", 64'(rd), 64'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule